// File: doc/BRIEF.md
# Aspect Mode Controller and Output Selector

This block sits in the control path of a widescreen picture compressor. Each video line starts at the rising edge of a line reference input. From that edge the block counts its position within the line. From the position and a latched operating mode it produces four things:

- a clamp window for the input stage;
- a read-start pulse and a read offset for the external line buffer;
- a flag that tells the buffer to read faster for compression;
- the per-cycle source selection of a four-way output selector.

The selector registers one of four sample buses onto the output: the line-buffer (post-filter) sample, the clamped input taken directly, a black reference level, or a side-panel level. Three mode inputs are decoded into five operating modes:

- buffered pass-through;
- direct pass-through;
- compressed picture placed at the left, centre or right.

In the compressed modes the shortened picture (1984 cycles by default) is placed inside the 2808-cycle active region. The rest of the active region is filled with the side-panel level. Everything outside the active region outputs black. All timing values are fixed parameters counted in cycles of the 54 MHz working clock.

Top module: `aspect_ctrl`

## Requirements
- R1: The mode inputs decode as follows: 000 is buffered pass-through, 010 is compress-left, 100 is compress-centre, 110 is compress-right and 001 is direct pass-through. The unlisted codes 011, 101 and 111 behave exactly as direct pass-through.
- R2: Only a rising edge of `line_ref` restarts the line position at 0. While `line_ref` stays high, the position keeps advancing by one per clock.
- R3: `clamp_win` is high exactly while the line position is in [84, 204), in every mode.
- R4: In direct pass-through, `src_sel` is 1 (direct input) for the whole line, `rd_start` stays low, `rd_offset` is 0 and `rd_compress` is 0.
- R5: In buffered pass-through, `src_sel` is 0 (buffer sample) for positions in [567, 3375) and 2 (black) elsewhere. `rd_start` pulses for one cycle at position 567, `rd_offset` is 0 and `rd_compress` is 0.
- R6: In a compress mode, `rd_compress` is 1 and `rd_offset` is 0 (left), 412 (centre) or 824 (right). Let the read begin be 567 + `rd_offset`. `src_sel` is 0 for the 1984 positions starting at the read begin, 3 (side level) for the rest of [567, 3375), and 2 elsewhere. `rd_start` pulses at the read begin.
- R7: A change of the mode inputs takes effect only on the clock that sees a rising edge of `line_ref`. Within a line, every output keeps following the mode latched at that line's edge.
- R8: `pix_out` equals, one clock later, the bus chosen by `src_sel` under the encoding 0 = `post_px`, 1 = `direct_px`, 2 = `black_px`, 3 = `side_px`.
- R9: During and right after reset, the mode is buffered pass-through and the position is parked at its last value 3455. So `src_sel` is 2, `clamp_win`, `rd_start` and `rd_compress` are 0, and `pix_out` is 0. A `line_ref` already high at reset release is not counted as an edge.
- R10: Without a new edge, the position stops at 3455 and stays there. The outputs then stay in their end-of-line state: black in the buffered and compress modes, and no further `rd_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 54 MHz working clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_ref | input | 1 | Line reference; its rising edge starts a line |
| mode_sel | input | 3 | Mode code, latched at each line edge |
| post_px | input | DW | Sample read from the line buffer after post-filtering |
| direct_px | input | DW | Clamped input sample that skips the buffer |
| black_px | input | DW | Black reference level |
| side_px | input | DW | Side-panel level |
| pix_out | output | DW | Registered output sample |
| src_sel | output | 2 | Current selector source (0 buffer, 1 direct, 2 black, 3 side) |
| clamp_win | output | 1 | Input clamp window |
| rd_start | output | 1 | One-cycle pulse at which the buffer read begins |
| rd_offset | output | $clog2(LINE_CYCLES) | Read start offset from the active-region start |
| rd_compress | output | 1 | Buffer readout runs at the compression rate |

## Verification
The hardest case to reach from the ports is a mode change that lands in the middle of a line. It needs a second, separate case: a reference pulse that stays high long enough that a level-sensitive restart would move the position. Both only show up when the timing of `mode_sel` and `line_ref` is independent of the line length. The stimulus therefore draws, for every line, a random length around 3456 cycles, a random reference pulse width, and a random cycle inside the line at which the mode code is overwritten. Directed lines add a long-held reference pulse, a mid-picture switch to direct mode, and a line left running past its end so that the position saturates.

// File: rtl/asp_pkg.sv
package asp_pkg;

    typedef enum logic [2:0] {
        MD_BYP_MEM  = 3'd0,
        MD_LEFT     = 3'd1,
        MD_CENTRE   = 3'd2,
        MD_RIGHT    = 3'd3,
        MD_BYP_FULL = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        SRC_POST   = 2'd0,
        SRC_DIRECT = 2'd1,
        SRC_BLACK  = 2'd2,
        SRC_SIDE   = 2'd3
    } src_e;

    // Mode table; codes outside it fall back to direct pass-through
    function automatic mode_e decode_mode(input logic [2:0] bits);
        case (bits)
            3'b000:  return MD_BYP_MEM;
            3'b010:  return MD_LEFT;
            3'b100:  return MD_CENTRE;
            3'b110:  return MD_RIGHT;
            default: return MD_BYP_FULL;
        endcase
    endfunction

endpackage

// File: rtl/asp_line_timer.sv
module asp_line_timer #(
    parameter int LINE_CYCLES = 3456,
    parameter int PW          = $clog2(LINE_CYCLES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_ref,
    output logic          line_edge,
    output logic [PW-1:0] pos
);

    localparam logic [PW-1:0] POS_LAST = PW'(LINE_CYCLES - 1);

    typedef struct packed {
        logic          ref_seen;
        logic [PW-1:0] pos;
    } tmr_t;

    tmr_t st_d, st_q;

    assign line_edge = line_ref & ~st_q.ref_seen;
    assign pos       = st_q.pos;

    always_comb begin
        st_d          = st_q;
        st_d.ref_seen = line_ref;
        if (line_edge) begin
            st_d.pos = '0;
        end else if (st_q.pos != POS_LAST) begin
            st_d.pos = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ref_seen <= 1'b1;
            st_q.pos      <= POS_LAST;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: an edge restarts the line at position zero
    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_edge |=> (pos == '0));

    // R10: with no edge the position stays parked at the end
    p_park_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == POS_LAST && !line_edge) |=> (pos == POS_LAST));

endmodule

// File: rtl/asp_mode_latch.sv
module asp_mode_latch
    import asp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_edge,
    input  logic [2:0] mode_sel,
    output mode_e      mode_cur
);

    typedef struct packed {
        mode_e mode;
    } ml_t;

    ml_t st_d, st_q;

    assign mode_cur = st_q.mode;

    always_comb begin
        st_d = st_q;
        if (line_edge) begin
            st_d.mode = decode_mode(mode_sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MD_BYP_MEM;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: the mode only moves at a line edge
    p_mode_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !line_edge |=> $stable(mode_cur));

    // R1: an unlisted code lands on direct pass-through
    p_fallback_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (line_edge && mode_sel == 3'b111) |=> (mode_cur == MD_BYP_FULL));

endmodule

// File: rtl/asp_window_gen.sv
module asp_window_gen
    import asp_pkg::*;
#(
    parameter int PW          = 12,
    parameter int CLAMP_OPEN  = 84,
    parameter int CLAMP_CLOSE = 204,
    parameter int ACT_START   = 567,
    parameter int ACT_LEN     = 2808,
    parameter int COMP_LEN    = 1984
) (
    input  logic [PW-1:0] pos,
    input  mode_e         mode,
    output src_e          sel,
    output logic          clamp_win,
    output logic          rd_start,
    output logic [PW-1:0] rd_offset,
    output logic          rd_compress
);

    localparam int            SLACK  = ACT_LEN - COMP_LEN;
    localparam logic [PW-1:0] A_S    = PW'(ACT_START);
    localparam logic [PW-1:0] A_E    = PW'(ACT_START + ACT_LEN);
    localparam logic [PW-1:0] C_LEN  = PW'(COMP_LEN);
    localparam logic [PW-1:0] CL_O   = PW'(CLAMP_OPEN);
    localparam logic [PW-1:0] CL_C   = PW'(CLAMP_CLOSE);

    // Placement offsets for left, centre, right: 0, half slack, full slack
    logic [PW-1:0] place_off [3];
    for (genvar g = 0; g < 3; g++) begin : g_place
        assign place_off[g] = PW'((SLACK * g) / 2);
    end

    logic [PW-1:0] rd_begin;
    logic [PW-1:0] comp_end;
    logic          in_act;
    logic          in_comp;

    always_comb begin
        rd_offset   = '0;
        rd_compress = 1'b0;
        case (mode)
            MD_LEFT:   begin rd_offset = place_off[0]; rd_compress = 1'b1; end
            MD_CENTRE: begin rd_offset = place_off[1]; rd_compress = 1'b1; end
            MD_RIGHT:  begin rd_offset = place_off[2]; rd_compress = 1'b1; end
            default:   begin rd_offset = '0;           rd_compress = 1'b0; end
        endcase

        rd_begin  = A_S + rd_offset;
        comp_end  = rd_begin + C_LEN;
        in_act    = (pos >= A_S) && (pos < A_E);
        in_comp   = (pos >= rd_begin) && (pos < comp_end);
        clamp_win = (pos >= CL_O) && (pos < CL_C);

        case (mode)
            MD_BYP_FULL: sel = SRC_DIRECT;
            MD_BYP_MEM:  sel = in_act ? SRC_POST : SRC_BLACK;
            default:     sel = !in_act ? SRC_BLACK : (in_comp ? SRC_POST : SRC_SIDE);
        endcase

        rd_start = (mode != MD_BYP_FULL) && (pos == rd_begin);
    end

endmodule

// File: rtl/asp_out_mux.sv
module asp_out_mux
    import asp_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  src_e                sel,
    input  logic [3:0][DW-1:0]  src_px,
    output logic [DW-1:0]       pix
);

    typedef struct packed {
        logic [DW-1:0] pix;
    } om_t;

    om_t st_d, st_q;

    assign pix = st_q.pix;

    always_comb begin
        st_d     = st_q;
        st_d.pix = src_px[sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pix <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/aspect_ctrl.sv
module aspect_ctrl
    import asp_pkg::*;
#(
    parameter int DW          = 10,
    parameter int LINE_CYCLES = 3456,
    parameter int CLAMP_OPEN  = 84,
    parameter int CLAMP_CLOSE = 204,
    parameter int ACT_START   = 567,
    parameter int ACT_LEN     = 2808,
    parameter int COMP_LEN    = 1984
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           line_ref,
    input  logic [2:0]                     mode_sel,
    input  logic [DW-1:0]                  post_px,
    input  logic [DW-1:0]                  direct_px,
    input  logic [DW-1:0]                  black_px,
    input  logic [DW-1:0]                  side_px,
    output logic [DW-1:0]                  pix_out,
    output logic [1:0]                     src_sel,
    output logic                           clamp_win,
    output logic                           rd_start,
    output logic [$clog2(LINE_CYCLES)-1:0] rd_offset,
    output logic                           rd_compress
);

    localparam int PW = $clog2(LINE_CYCLES);

    logic               line_edge;
    logic [PW-1:0]      pos;
    mode_e              mode_cur;
    src_e               sel;
    logic [3:0][DW-1:0] px_bus;

    asp_line_timer #(
        .LINE_CYCLES (LINE_CYCLES),
        .PW          (PW)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_ref  (line_ref),
        .line_edge (line_edge),
        .pos       (pos)
    );

    asp_mode_latch u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_edge (line_edge),
        .mode_sel  (mode_sel),
        .mode_cur  (mode_cur)
    );

    asp_window_gen #(
        .PW          (PW),
        .CLAMP_OPEN  (CLAMP_OPEN),
        .CLAMP_CLOSE (CLAMP_CLOSE),
        .ACT_START   (ACT_START),
        .ACT_LEN     (ACT_LEN),
        .COMP_LEN    (COMP_LEN)
    ) u_win (
        .pos         (pos),
        .mode        (mode_cur),
        .sel         (sel),
        .clamp_win   (clamp_win),
        .rd_start    (rd_start),
        .rd_offset   (rd_offset),
        .rd_compress (rd_compress)
    );

    assign px_bus  = {side_px, black_px, direct_px, post_px};
    assign src_sel = sel;

    asp_out_mux #(
        .DW (DW)
    ) u_mux (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .src_px (px_bus),
        .pix    (pix_out)
    );

    // R6: a read start always coincides with the buffer sample being chosen
    p_start_on_post_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |-> (src_sel == 2'd0));

    // R5: a read start is a single-cycle pulse
    p_single_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start);

    // R3: the clamp window never overlaps picture or side panel output
    p_clamp_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_win |-> (src_sel == 2'd1 || src_sel == 2'd2));

    // R8: a side selection reaches the output one clock later
    p_side_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'd3) |=> (pix_out == $past(side_px)));

endmodule

// File: tb/aspect_ctrl_bench.sv
module aspect_ctrl_bench;

    localparam int DW     = 10;
    localparam int LINE   = 3456;
    localparam int LAST   = 3455;
    localparam int ACT_S  = 567;
    localparam int ACT_E  = 3375;
    localparam int COMP_L = 1984;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          line_ref;
    logic [2:0]    mode_sel;
    logic [DW-1:0] post_px, direct_px, black_px, side_px;
    logic [DW-1:0] pix_out;
    logic [1:0]    src_sel;
    logic          clamp_win, rd_start, rd_compress;
    logic [11:0]   rd_offset;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // bench model state
    int pos_m   = LAST;
    int ref_m   = 1;
    int mode_m  = 0;
    bit bad_m   = 0;
    int pix_m   = 0;

    always #4 clk = ~clk;

    aspect_ctrl u_aspect_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_ref    (line_ref),
        .mode_sel    (mode_sel),
        .post_px     (post_px),
        .direct_px   (direct_px),
        .black_px    (black_px),
        .side_px     (side_px),
        .pix_out     (pix_out),
        .src_sel     (src_sel),
        .clamp_win   (clamp_win),
        .rd_start    (rd_start),
        .rd_offset   (rd_offset),
        .rd_compress (rd_compress)
    );

    // mode numbering of the bench: 0 buffered, 1 left, 2 centre, 3 right, 4 direct
    function automatic int dec_m(input logic [2:0] b);
        case (b)
            3'b000:  return 0;
            3'b010:  return 1;
            3'b100:  return 2;
            3'b110:  return 3;
            default: return 4;
        endcase
    endfunction

    function automatic int exp_off(input int md);
        case (md)
            2:       return 412;
            3:       return 824;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_sel(input int p, input int md);
        int rb;
        rb = ACT_S + exp_off(md);
        if (md == 4) return 1;
        if (p < ACT_S || p >= ACT_E) return 2;
        if (md == 0) return 0;
        if (p >= rb && p < rb + COMP_L) return 0;
        return 3;
    endfunction

    function automatic int pick(input int s);
        case (s)
            0:       return int'(post_px);
            1:       return int'(direct_px);
            2:       return int'(black_px);
            default: return int'(side_px);
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (pos %0d)", tag, what, act, exp, pos_m);
        end
    endtask

    task automatic tick();
        string tg;
        int    rs;
        @(negedge clk);
        if (!rst_n) begin
            pos_m = LAST; ref_m = 1; mode_m = 0; bad_m = 0; pix_m = 0;
        end else begin
            pix_m = pick(exp_sel(pos_m, mode_m));
            if (line_ref && ref_m == 0) begin
                pos_m  = 0;
                mode_m = dec_m(mode_sel);
                bad_m  = (mode_sel == 3'b011 || mode_sel == 3'b101 || mode_sel == 3'b111);
            end else if (pos_m != LAST) begin
                pos_m++;
            end
            ref_m = int'(line_ref);
        end
        if (!rst_n)          tg = "R9";
        else if (bad_m)      tg = "R1";
        else if (mode_m == 4) tg = "R4";
        else if (mode_m == 0) tg = "R5";
        else                 tg = "R6";
        rs = (mode_m != 4 && pos_m == ACT_S + exp_off(mode_m)) ? 1 : 0;
        check(int'(src_sel) == exp_sel(pos_m, mode_m), tg, "src_sel", int'(src_sel), exp_sel(pos_m, mode_m));
        check(int'(rd_start) == rs, tg, "rd_start", int'(rd_start), rs);
        check(int'(rd_offset) == exp_off(mode_m), tg, "rd_offset", int'(rd_offset), exp_off(mode_m));
        check(int'(rd_compress) == ((mode_m >= 1 && mode_m <= 3) ? 1 : 0), tg, "rd_compress",
              int'(rd_compress), (mode_m >= 1 && mode_m <= 3) ? 1 : 0);
        check(int'(clamp_win) == ((pos_m >= 84 && pos_m < 204) ? 1 : 0), "R3", "clamp_win",
              int'(clamp_win), (pos_m >= 84 && pos_m < 204) ? 1 : 0);
        check(int'(pix_out) == pix_m, "R8", "pix_out", int'(pix_out), pix_m);
        post_px   = DW'($urandom);
        direct_px = DW'($urandom);
        black_px  = DW'($urandom);
        side_px   = DW'($urandom);
    endtask

    task automatic run_line(input int len, input int hi, input logic [2:0] bits,
                            input int chg_at, input logic [2:0] chg_bits);
        for (int i = 0; i < len; i++) begin
            line_ref = (i < hi);
            if (i == 0)      mode_sel = bits;
            if (i == chg_at) mode_sel = chg_bits;
            tick();
        end
    endtask

    initial begin
        void'($urandom(32'd4981));
        rst_n = 1'b0; line_ref = 1'b1; mode_sel = 3'b110;
        post_px = '0; direct_px = '0; black_px = '0; side_px = '0;
        repeat (5) tick();
        // R9: reset state seen at the ports
        check(src_sel == 2'd2, "R9", "reset src_sel", int'(src_sel), 2);
        check(pix_out == '0, "R9", "reset pix_out", int'(pix_out), 0);
        check(!clamp_win && !rd_start && !rd_compress, "R9", "reset strobes",
              int'({clamp_win, rd_start, rd_compress}), 0);
        rst_n = 1'b1;
        // line_ref still high at release: not an edge (R9)
        repeat (120) tick();
        check(clamp_win == 1'b0, "R9", "no edge at release", int'(clamp_win), 0);
        line_ref = 1'b0;
        tick();

        // R2: reference held high for 150 cycles must not restart the count
        run_line(100, 150, 3'b010, -1, 3'b000);
        check(clamp_win == 1'b1, "R2", "clamp at position 99", int'(clamp_win), 1);
        run_line(LINE - 100, 50, 3'b010, -1, 3'b000);

        // R7: switch to direct mode mid-picture; the left picture continues
        run_line(1000, 20, 3'b010, -1, 3'b000);
        run_line(20, 0, 3'b001, -1, 3'b001);
        check(src_sel == 2'd0, "R7", "mode held mid-line", int'(src_sel), 0);
        run_line(LINE - 1020, 0, 3'b001, -1, 3'b001);

        // every code of the table, full lines
        for (int b = 0; b < 8; b++) begin
            run_line(LINE, 8, 3'(b), -1, 3'b000);
        end

        // R10: no edge for a long time, position parks at the end
        run_line(LINE + 600, 30, 3'b100, -1, 3'b000);
        check(src_sel == 2'd2, "R10", "parked src_sel", int'(src_sel), 2);
        check(rd_start == 1'b0, "R10", "parked rd_start", int'(rd_start), 0);

        // constrained random lines
        for (int n = 0; n < 20; n++) begin
            run_line(LINE - 40 + int'($urandom_range(0, 80)), int'($urandom_range(2, 60)),
                     3'($urandom_range(0, 7)), int'($urandom_range(200, 3000)),
                     3'($urandom_range(0, 7)));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule